// File: doc/BRIEF.md
# Logic Analyzer Capture Sequencer

This block sequences the write side of a circular sample memory inside an on-chip logic analyzer. After a start request it produces a write enable and a write address for each sample. It also keeps a read pointer that always marks the oldest valid sample in the ring. When a capture completes, the host can read the ring in order, beginning at the read pointer. The sample RAM, the trigger comparators and the host register access all sit outside this block.

Three capture policies are supported:
- **Windowed:** keeps a programmable number of samples from before the trigger, then records enough samples after the trigger to fill the ring.
- **Immediate:** fills the ring once, straight away.
- **Gated:** records a sample only on cycles where the trigger input is high.

The trigger location and the mode must be held steady while a capture runs. A finished capture stays frozen until the next reset.

Top module: `capture_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters the following state, and after reset that state shows on the ports: `curState` = 0 (idle), `wrPtr` = 0, `rdPtr` = 0 and `wrEn` = 0.
- R2: The `capMode` encoding is 0 = windowed, 1 = immediate, 2 = gated. Code 3 is reserved: a start request with it leaves `curState` at 0 and `wrEn` low.
- R3: A start request seen at an edge while idle clears both pointers to 0. For the windowed and immediate modes it also drives `wrEn` high in the following cycle. A start request seen in any state other than idle has no effect.
- R4: In windowed mode, `wrPtr` is 0 in the first write cycle and advances by one each cycle. `rdPtr` holds at 0. After `trigLoc` writes, `curState` reads 2 (armed) and `wrPtr` equals `trigLoc`. If `trigLoc` is 0, `curState` is 2 from the first write cycle.
- R5: While armed (state 2) with the trigger low, a sample is written and both pointers advance each cycle. The distance (`wrPtr` − `rdPtr`) mod depth stays equal to `trigLoc`, so the ring holds exactly `trigLoc` samples from before the trigger.
- R6: In windowed mode, the sample written in the cycle the trigger is first seen while armed is the first post-trigger sample. After depth − `trigLoc` post-trigger samples, `curState` becomes 5 (done) and (`wrPtr` + 1) mod depth equals `rdPtr`. The ring then holds `trigLoc` older samples, followed by the trigger sample at offset `trigLoc` from `rdPtr`.
- R7: In windowed mode, if the trigger is already high when the pre-trigger region fills, the capture runs straight through. It takes exactly depth write cycles and ends with `wrPtr` = depth − 1 and `rdPtr` = 0.
- R8: Immediate mode ignores the trigger. `wrEn` stays high for exactly depth consecutive cycles, with `wrPtr` equal to the cycle index. It ends with `wrPtr` = depth − 1, `rdPtr` = 0, `curState` = 5, and `wrEn` low on the following cycle.
- R9: In gated mode (state 4), `wrEn` follows the trigger input in the same cycle, and `wrPtr` advances only after a cycle with the trigger high. After depth such writes, `curState` becomes 5 with `wrPtr` = depth − 1 and `rdPtr` = 0.
- R10: In the done state, `wrEn` is low and the state and both pointers stay fixed until reset. Pointers are log2(depth) bits wide and wrap from depth − 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request to begin a capture, honoured only when idle |
| trigger | input | 1 | Trigger condition from the comparators |
| capMode | input | 2 | Capture policy: 0 windowed, 1 immediate, 2 gated |
| trigLoc | input | log2(DEPTH) | Number of pre-trigger samples kept in windowed mode |
| curState | output | 3 | 0 idle, 1 prefill, 2 armed, 3 post-trigger fill, 4 gated, 5 done |
| wrPtr | output | log2(DEPTH) | Sample RAM write address |
| rdPtr | output | log2(DEPTH) | Address of the oldest valid sample |
| wrEn | output | 1 | Sample RAM write enable |

## Verification
The assertions check several properties on every cycle:
- Both pointers stay inside the ring.
- The read pointer holds at zero during prefill.
- While armed, the write-to-read distance equals the trigger location.
- Entering the done state always leaves the write pointer just behind the read pointer.
- The done state freezes everything.
- In gated mode the write pointer holds while the trigger is low.

Other behaviours need the bench's scenarios, which model the ring as an array:
- the exact number of samples written for each trigger location and trigger delay;
- the ordering of the ring contents, including where the trigger sample lands;
- straight-through capture when the trigger is already high;
- the immediate-mode count;
- the cycle-by-cycle match between `wrEn` and the trigger in gated mode.

// File: rtl/capture_pkg.sv
package capture_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PREFILL = 3'd1,
    ST_ARMED   = 3'd2,
    ST_POST    = 3'd3,
    ST_GATED   = 3'd4,
    ST_DONE    = 3'd5
  } capState_t;

  typedef enum logic [1:0] {
    MODE_WINDOW    = 2'd0,
    MODE_IMMEDIATE = 2'd1,
    MODE_GATED     = 2'd2,
    MODE_RESERVED  = 2'd3
  } capMode_t;

  typedef struct packed {
    logic clrPtrs;
    logic advWr;
    logic advRd;
  } ptrCmd_t;

endpackage

// File: rtl/capture_ptrs.sv
module capture_ptrs
  import capture_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  ptrCmd_t       cmd,
  input  logic [PW-1:0] trigLoc,
  output logic [PW-1:0] wrPtr,
  output logic [PW-1:0] rdPtr,
  output logic          locZero,
  output logic          preFull,
  output logic          lastSlot
);

  localparam logic [PW-1:0] LastIdx = PW'(DEPTH - 1);

  logic [PW-1:0] wrNext;
  logic [PW-1:0] rdNext;

  function automatic logic [PW-1:0] wrapInc(input logic [PW-1:0] p);
    return (p == LastIdx) ? '0 : p + 1'b1;
  endfunction

  assign wrNext   = wrapInc(wrPtr);
  assign rdNext   = wrapInc(rdPtr);
  assign locZero  = (trigLoc == '0);
  assign preFull  = (wrNext == trigLoc);
  assign lastSlot = (wrNext == rdPtr);

  always_ff @(posedge clk) begin
    if (rst || cmd.clrPtrs) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (cmd.advWr) wrPtr <= wrNext;
      if (cmd.advRd) rdPtr <= rdNext;
    end
  end

  // R10: pointers never leave the ring
  always_comb begin
    if (!rst) begin
      a_r10_ptr_range: assert (32'(wrPtr) < DEPTH && 32'(rdPtr) < DEPTH)
        else $error("pointer outside ring");
    end
  end

  // R5: the read pointer never moves on its own
  a_r5_rd_only_with_wr: assert property (@(posedge clk) disable iff (rst)
    (cmd.advRd && !cmd.clrPtrs) |-> cmd.advWr);

endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import capture_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      startReq,
  input  logic      trigger,
  input  logic [1:0] capMode,
  input  logic      locZero,
  input  logic      preFull,
  input  logic      lastSlot,
  output capState_t state,
  output ptrCmd_t   cmd,
  output logic      wrEn
);

  capState_t stateNext;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          unique case (capMode_t'(capMode))
            MODE_WINDOW: begin
              cmd.clrPtrs = 1'b1;
              stateNext   = locZero ? ST_ARMED : ST_PREFILL;
            end
            MODE_IMMEDIATE: begin
              cmd.clrPtrs = 1'b1;
              stateNext   = ST_POST;
            end
            MODE_GATED: begin
              cmd.clrPtrs = 1'b1;
              stateNext   = ST_GATED;
            end
            default: stateNext = ST_IDLE;
          endcase
        end
      end
      ST_PREFILL: begin
        cmd.advWr = 1'b1;
        if (preFull) stateNext = ST_ARMED;
      end
      ST_ARMED: begin
        if (trigger) begin
          if (lastSlot) stateNext = ST_DONE;
          else begin
            cmd.advWr = 1'b1;
            stateNext = ST_POST;
          end
        end else begin
          cmd.advWr = 1'b1;
          cmd.advRd = 1'b1;
        end
      end
      ST_POST: begin
        if (lastSlot) stateNext = ST_DONE;
        else          cmd.advWr = 1'b1;
      end
      ST_GATED: begin
        if (trigger) begin
          if (lastSlot) stateNext = ST_DONE;
          else          cmd.advWr = 1'b1;
        end
      end
      ST_DONE: stateNext = ST_DONE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    unique case (state)
      ST_PREFILL, ST_ARMED, ST_POST: wrEn = 1'b1;
      ST_GATED:                      wrEn = trigger;
      default:                       wrEn = 1'b0;
    endcase
  end

  // R3: an accepted windowed or immediate start enables writing next cycle
  a_r3_start_enables: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && startReq &&
     (capMode == MODE_WINDOW || capMode == MODE_IMMEDIATE)) |=> wrEn);

  // R2: a reserved mode code leaves the block idle
  a_r2_reserved_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && capMode == MODE_RESERVED) |=> (state == ST_IDLE && !wrEn));

endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer
  import capture_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          startReq,
  input  logic          trigger,
  input  logic [1:0]    capMode,
  input  logic [PW-1:0] trigLoc,
  output logic [2:0]    curState,
  output logic [PW-1:0] wrPtr,
  output logic [PW-1:0] rdPtr,
  output logic          wrEn
);

  capState_t stateQ;
  ptrCmd_t   ptrCmd;
  logic      locZero;
  logic      preFull;
  logic      lastSlot;

  capture_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .trigger  (trigger),
    .capMode  (capMode),
    .locZero  (locZero),
    .preFull  (preFull),
    .lastSlot (lastSlot),
    .state    (stateQ),
    .cmd      (ptrCmd),
    .wrEn     (wrEn)
  );

  capture_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .cmd      (ptrCmd),
    .trigLoc  (trigLoc),
    .wrPtr    (wrPtr),
    .rdPtr    (rdPtr),
    .locZero  (locZero),
    .preFull  (preFull),
    .lastSlot (lastSlot)
  );

  assign curState = stateQ;

  // assertion helpers: ring distance and wrapped successor of the write pointer
  logic [PW:0] ptrGap;
  logic [PW:0] wrSucc;
  assign ptrGap = (wrPtr >= rdPtr) ? {1'b0, wrPtr} - {1'b0, rdPtr}
                                   : {1'b0, wrPtr} + (PW+1)'(DEPTH) - {1'b0, rdPtr};
  assign wrSucc = (32'(wrPtr) == DEPTH - 1) ? '0 : {1'b0, wrPtr} + 1'b1;

  // R4: read pointer held at zero during prefill
  a_r4_prefill_rd_zero: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_PREFILL) |-> (rdPtr == '0));

  // R5: armed ring keeps exactly trigLoc older samples
  a_r5_armed_gap: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_ARMED) |-> (ptrGap == {1'b0, trigLoc}));

  // R6: finishing a capture leaves the write pointer just behind the read pointer
  a_r6_done_ring_full: assert property (@(posedge clk) disable iff (rst)
    $rose(stateQ == ST_DONE) |-> (wrSucc == {1'b0, rdPtr}));

  // R9: gated mode holds the write pointer while the trigger is low
  a_r9_gated_hold: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_GATED && !trigger) |=> $stable(wrPtr));

  // R10: done is frozen with writing disabled
  a_r10_done_frozen: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_DONE) |=> (stateQ == ST_DONE && !wrEn && $stable(wrPtr) && $stable(rdPtr)));

endmodule

// File: tb/capture_sequencer_bench.sv
module capture_sequencer_bench;

  localparam int DEPTH = 8;
  localparam int PW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst;
  logic          startReq;
  logic          trigger;
  logic [1:0]    capMode;
  logic [PW-1:0] trigLoc;
  logic [2:0]    curState;
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;
  logic          wrEn;

  int total = 0;
  int bad = 0;
  int ring [DEPTH];
  bit finished = 0;

  always #5 clk = ~clk;

  capture_sequencer #(.DEPTH(DEPTH)) u_capture_sequencer (
    .clk(clk), .rst(rst), .startReq(startReq), .trigger(trigger),
    .capMode(capMode), .trigLoc(trigLoc), .curState(curState),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .wrEn(wrEn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; startReq = 1'b0; trigger = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic runWindow(input int loc, input int tDelay);
    int idx = 0;
    int tStar;
    int expWrites;
    doReset();
    capMode = 2'd0; trigLoc = PW'(loc); startReq = 1'b1;
    @(negedge clk);
    tStar = (tDelay > loc) ? tDelay : loc;
    expWrites = tStar + DEPTH - loc;
    for (int guard = 0; guard < 100; guard++) begin
      trigger = (idx >= tDelay);
      #1;
      if (curState == 3'd5) break;
      chk(wrEn == 1'b1, "R4", int'(wrEn), 1);
      chk(int'(wrPtr) == idx % DEPTH, "R4", int'(wrPtr), idx % DEPTH);
      if (idx <= loc) chk(rdPtr == '0, "R4", int'(rdPtr), 0);
      if (idx == loc) begin
        chk(curState == 3'd2, "R4", int'(curState), 2);
        chk((int'(wrPtr) - int'(rdPtr) + DEPTH) % DEPTH == loc, "R5",
            (int'(wrPtr) - int'(rdPtr) + DEPTH) % DEPTH, loc);
      end
      ring[wrPtr] = idx;
      idx++;
      @(negedge clk);
    end
    chk(idx == expWrites, (tDelay <= loc) ? "R7" : "R6", idx, expWrites);
    chk(int'(wrPtr) == (expWrites - 1) % DEPTH, "R6", int'(wrPtr), (expWrites - 1) % DEPTH);
    chk(int'(rdPtr) == (tStar - loc) % DEPTH, "R6", int'(rdPtr), (tStar - loc) % DEPTH);
    chk(wrEn == 1'b0, "R10", int'(wrEn), 0);
    for (int j = 0; j < DEPTH; j++)
      chk(ring[(int'(rdPtr) + j) % DEPTH] == tStar - loc + j, "R6",
          ring[(int'(rdPtr) + j) % DEPTH], tStar - loc + j);
    if (tDelay <= loc) begin
      chk(wrPtr == PW'(DEPTH - 1), "R7", int'(wrPtr), DEPTH - 1);
      chk(rdPtr == '0, "R7", int'(rdPtr), 0);
    end
  endtask

  task automatic runImmediate(input int seed);
    int idx = 0;
    doReset();
    capMode = 2'd1; trigLoc = PW'(seed); startReq = 1'b1;
    @(negedge clk);
    for (int guard = 0; guard < 100; guard++) begin
      trigger = ((idx + seed) % 3) == 0;
      #1;
      if (curState == 3'd5) break;
      chk(wrEn == 1'b1, "R8", int'(wrEn), 1);
      chk(int'(wrPtr) == idx, "R8", int'(wrPtr), idx);
      chk(rdPtr == '0, "R8", int'(rdPtr), 0);
      idx++;
      @(negedge clk);
    end
    chk(idx == DEPTH, "R8", idx, DEPTH);
    chk(wrPtr == PW'(DEPTH - 1), "R8", int'(wrPtr), DEPTH - 1);
    chk(rdPtr == '0, "R8", int'(rdPtr), 0);
    chk(wrEn == 1'b0, "R8", int'(wrEn), 0);
  endtask

  task automatic runGated(input int pat);
    int cyc = 0;
    int writes = 0;
    doReset();
    capMode = 2'd2; trigLoc = '0; startReq = 1'b1;
    @(negedge clk);
    for (int guard = 0; guard < 200; guard++) begin
      trigger = (pat == 0) ? ((cyc % 3) == 1) : (((cyc * 7) % 5) < 2);
      #1;
      if (curState == 3'd5) break;
      chk(curState == 3'd4, "R9", int'(curState), 4);
      chk(wrEn == trigger, "R9", int'(wrEn), int'(trigger));
      chk(int'(wrPtr) == writes, "R9", int'(wrPtr), writes);
      if (trigger) begin
        ring[wrPtr] = cyc;
        writes++;
      end
      cyc++;
      @(negedge clk);
    end
    chk(writes == DEPTH, "R9", writes, DEPTH);
    chk(wrPtr == PW'(DEPTH - 1), "R9", int'(wrPtr), DEPTH - 1);
    chk(rdPtr == '0, "R9", int'(rdPtr), 0);
  endtask

  initial begin
    rst = 1'b1; startReq = 1'b0; trigger = 1'b0; capMode = 2'd0; trigLoc = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(curState == 3'd0, "R1", int'(curState), 0);
    chk(wrPtr == '0, "R1", int'(wrPtr), 0);
    chk(rdPtr == '0, "R1", int'(rdPtr), 0);
    chk(wrEn == 1'b0, "R1", int'(wrEn), 0);
    rst = 1'b0;

    // R2 reserved mode code
    capMode = 2'd3; startReq = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(curState == 3'd0, "R2", int'(curState), 0);
      chk(wrEn == 1'b0, "R2", int'(wrEn), 0);
    end

    // R4 R5 R6 R7 sweep of trigger location and trigger delay
    for (int loc = 0; loc < DEPTH; loc++)
      foreach (ring[d]) if (d < 5) runWindow(loc, d * 4 - 1 < 0 ? 0 : d * 4 - 1);

    // R8 immediate
    for (int s = 0; s < 3; s++) runImmediate(s);

    // R9 gated
    runGated(0);
    runGated(1);

    // R3 R10: start held high in done state is ignored
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      startReq = 1'b1; trigger = k[0];
      #1;
      chk(curState == 3'd5, "R10", int'(curState), 5);
      chk(wrPtr == PW'(DEPTH - 1), "R3", int'(wrPtr), DEPTH - 1);
      chk(wrEn == 1'b0, "R10", int'(wrEn), 0);
    end

    // R3 start during an active capture is ignored
    doReset();
    capMode = 2'd1; startReq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    capMode = 2'd0;
    @(negedge clk);
    chk(int'(wrPtr) == 2, "R3", int'(wrPtr), 2);
    chk(curState == 3'd3, "R3", int'(curState), 3);

    // R1 reset out of a running capture
    doReset();
    #1;
    chk(curState == 3'd0 && wrPtr == '0 && !wrEn, "R1", int'(curState), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule